// File: doc/BRIEF.md
# Half-Spectrum Two-Bin FFT Combiner

This block assembles a 4096-point spectrum of a real signal from four 1024-point transforms of the signal's decimated phases (sample phases 0, 1, 2 and 3, called A, B, C and D). Each clock it takes one bin index k (0 to 1023) together with the complex value of each sub-transform at that bin. It returns the two bins of the large spectrum that lie in the lower half, k and k+1024. The upper 2048 bins of a real signal's spectrum mirror the lower ones, so a power-spectrum path needs only these two.

Internally, a quarter-wave cosine table provides the twiddle factors as signed integers scaled by 2^20. Twelve real multiplies per output bin are grouped into six complex products. Each product is rounded back to data scale before a four-term adder. The second-power twiddle for the upper bin is the negated lower one, so only five distinct twiddle angles are looked up per cycle. The block accepts a new set of inputs every clock, and the results appear two cycles later with a matching valid strobe and both bin indices.

Top module: `fft_half_combiner`

## Requirements
- R1: With W = exp(-j2π/4096), the lower output equals A + W^k·B + W^2k·C + W^3k·D, evaluated with the fixed-point rules of R3 and R4.
- R2: The upper output equals A + W^(k+1024)·B + W^2(k+1024)·C + W^3(k+1024)·D, evaluated with the same rules.
- R3: Each twiddle W^m is held as a real part round(cos(2πm/4096)·2^20) and an imaginary part round(−sin(2πm/4096)·2^20), rounded to nearest with ties away from zero.
- R4: Each real twiddle-by-data product t·x is reduced to (t·x + 2^19) >>> 20, an arithmetic shift, before it is summed. The real part of a term is rnd(Wr·xr) − rnd(Wi·xi) and the imaginary part is rnd(Wi·xr) + rnd(Wr·xi).
- R5: The second-power twiddle of the upper bin is the exact negation of both parts of the lower bin's second-power twiddle.
- R6: A set is accepted on every clock with in_valid high. out_valid is high exactly two clocks after in_valid was sampled high, and low otherwise.
- R7: With each result, out_lo_bin carries k and out_hi_bin carries k+1024, both as 12-bit unsigned values.
- R8: While rst_n is low at a clock edge (synchronous, active low), out_valid and all result and bin outputs clear to zero.
- R9: At k = 0 the lower result is exactly A+B+C+D in both parts, since the unit twiddle passes data unchanged.
- R10: Full-scale inputs (every part at +131071 or at −131072) give results that fit in the 22-bit signed outputs without wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input set present this cycle |
| in_bin | input | 10 | Sub-transform bin index k |
| a_re | input | 18 | Phase-0 sub-transform, real part (signed) |
| a_im | input | 18 | Phase-0 sub-transform, imaginary part (signed) |
| b_re | input | 18 | Phase-1 sub-transform, real part (signed) |
| b_im | input | 18 | Phase-1 sub-transform, imaginary part (signed) |
| c_re | input | 18 | Phase-2 sub-transform, real part (signed) |
| c_im | input | 18 | Phase-2 sub-transform, imaginary part (signed) |
| d_re | input | 18 | Phase-3 sub-transform, real part (signed) |
| d_im | input | 18 | Phase-3 sub-transform, imaginary part (signed) |
| out_valid | output | 1 | Results present this cycle |
| out_lo_bin | output | 12 | Index of the lower result bin (k) |
| out_hi_bin | output | 12 | Index of the upper result bin (k+1024) |
| lo_re | output | 22 | Lower bin, real part (signed) |
| lo_im | output | 22 | Lower bin, imaginary part (signed) |
| hi_re | output | 22 | Upper bin, real part (signed) |
| hi_im | output | 22 | Upper bin, imaginary part (signed) |

## Verification
The assertions take for granted that in_valid is held low across reset release, so that the two-cycle valid relation only covers sets accepted after reset. They also assume each data part is any 18-bit two's complement value, which bounds every output by seven times the input full scale. The unit-twiddle check relies on the table entry at angle zero being exactly 2^20 with a zero imaginary part. The stimulus draws every data part uniformly over the whole 18-bit range and every bin over 0 to 1023, with idle gaps. It drives in_valid low before reset is released and adds directed full-scale, single-input and tie-rounding sets.

// File: rtl/fftc_pkg.sv
// Package: shared constants for the half-spectrum combiner.
// Assumes the twiddle scaling is a power of two and tables are quarter-wave.
package fftc_pkg;
    localparam int TW_FRAC  = 20;   // fraction bits of each twiddle part
    localparam int TW_WIDTH = 22;   // twiddle width, holds +/-2^20
    localparam int DATA_W   = 18;   // default data part width
endpackage

// File: rtl/fftc_twiddle.sv
// Module: fftc_twiddle
// Returns cos and -sin of 2*pi*m/NPT, scaled by 2^FRAC, for NANG angles at once.
// Assumes NPT is a power of two of at least 8; a quarter-wave cosine table of
// NPT/4+1 entries is computed at start-up, and all other quadrants are folded onto it.
module fftc_twiddle #(
    parameter int NPT  = 4096,
    parameter int FRAC = fftc_pkg::TW_FRAC,
    parameter int TW   = fftc_pkg::TW_WIDTH,
    parameter int NANG = 5,
    localparam int AW  = $clog2(NPT)
) (
    input  logic [AW-1:0]          ang [NANG],
    output logic signed [TW-1:0]   wr  [NANG],
    output logic signed [TW-1:0]   wi  [NANG]
);
    localparam int  Q      = NPT / 4;
    localparam int  QW     = AW - 2;
    localparam real TWO_PI = 6.283185307179586476925;
    localparam real SCALE  = 2.0 ** FRAC;

    logic signed [TW-1:0] qtab [0:Q];

    // Fill the quarter-wave cosine table, rounding to nearest (values are non-negative).
    initial begin
        for (int i = 0; i <= Q; i++) begin
            qtab[i] = TW'($rtoi($cos(TWO_PI * real'(i) / real'(NPT)) * SCALE + 0.5));
        end
    end

    // Fold an angle index onto the quarter table to get its scaled cosine.
    function automatic logic signed [TW-1:0] cos_of(input logic [AW-1:0] m);
        logic [QW:0] r_up;
        logic [QW:0] r_dn;
        r_up = {1'b0, m[QW-1:0]};
        r_dn = (QW+1)'(Q) - r_up;
        case (m[AW-1:AW-2])
            2'd0:    return qtab[r_up];
            2'd1:    return -qtab[r_dn];
            2'd2:    return -qtab[r_up];
            default: return qtab[r_dn];
        endcase
    endfunction

    // One lookup pair per requested angle; -sin(m) equals cos(m + NPT/4).
    for (genvar g = 0; g < NANG; g++) begin : g_ang
        assign wr[g] = cos_of(ang[g]);
        assign wi[g] = cos_of(AW'(ang[g] + AW'(Q)));
    end
endmodule

// File: rtl/fftc_cmul.sv
// Module: fftc_cmul
// Registered complex product of a scaled twiddle and a data value. Each of the
// four real products is rounded back to data scale (add half, arithmetic shift)
// before the pair is combined. Assumes |twiddle| <= 2^FRAC.
module fftc_cmul #(
    parameter int DW   = fftc_pkg::DATA_W,
    parameter int TW   = fftc_pkg::TW_WIDTH,
    parameter int FRAC = fftc_pkg::TW_FRAC,
    localparam int PW  = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [TW-1:0] wr,
    input  logic signed [TW-1:0] wi,
    input  logic signed [DW-1:0] xr,
    input  logic signed [DW-1:0] xi,
    output logic signed [PW-1:0] pr,
    output logic signed [PW-1:0] pi
);
    localparam int FW = TW + DW;
    localparam int RW = DW + 1;
    localparam logic signed [FW-1:0] HALF = FW'(1) <<< (FRAC - 1);
    localparam logic signed [TW-1:0] ONE  = TW'(1) <<< FRAC;

    // Multiply, add one half LSB of the result, shift down by the twiddle scale.
    function automatic logic signed [RW-1:0] rmul(input logic signed [TW-1:0] t,
                                                  input logic signed [DW-1:0] x);
        logic signed [FW-1:0] full;
        full = t * x;
        full = full + HALF;
        return RW'(full >>> FRAC);
    endfunction

    // Product stage register: combine the rounded real products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr <= '0;
            pi <= '0;
        end else begin
            pr <= PW'(rmul(wr, xr)) - PW'(rmul(wi, xi));
            pi <= PW'(rmul(wi, xr)) + PW'(rmul(wr, xi));
        end
    end

    // R9: a unit twiddle must hand the data through unchanged.
    a_r9_unit_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (wr == ONE && wi == '0) |=> (pr == PW'($past(xr)) && pi == PW'($past(xi))));
endmodule

// File: rtl/fft_half_combiner.sv
// Module: fft_half_combiner
// Combines four interleaved NSUB-point sub-spectra into bins k and k+NSUB of a
// 4*NSUB-point spectrum. Stage 1 looks up twiddles and forms six rounded complex
// products; stage 2 adds them to A. Latency two clocks, one set per clock.
// Assumes in_valid is low when rst_n is released.
module fft_half_combiner #(
    parameter int NSUB = 1024,
    parameter int DW   = fftc_pkg::DATA_W,
    parameter int OW   = 22,
    parameter int TW   = fftc_pkg::TW_WIDTH,
    parameter int FRAC = fftc_pkg::TW_FRAC,
    localparam int KW  = $clog2(NSUB),
    localparam int BW  = KW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [KW-1:0]        in_bin,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [DW-1:0] c_re,
    input  logic signed [DW-1:0] c_im,
    input  logic signed [DW-1:0] d_re,
    input  logic signed [DW-1:0] d_im,
    output logic                 out_valid,
    output logic [BW-1:0]        out_lo_bin,
    output logic [BW-1:0]        out_hi_bin,
    output logic signed [OW-1:0] lo_re,
    output logic signed [OW-1:0] lo_im,
    output logic signed [OW-1:0] hi_re,
    output logic signed [OW-1:0] hi_im
);
    localparam int NPT   = 4 * NSUB;
    localparam int NANG  = 5;
    localparam int NPROD = 6;
    localparam int PW    = DW + 2;
    localparam longint LIMIT = 7 * (longint'(1) <<< (DW - 1));

    logic [BW-1:0]        k_ext;
    logic [BW-1:0]        ang  [NANG];
    logic signed [TW-1:0] tw_r [NANG];
    logic signed [TW-1:0] tw_i [NANG];
    logic signed [TW-1:0] sel_wr [NPROD];
    logic signed [TW-1:0] sel_wi [NPROD];
    logic signed [DW-1:0] sel_xr [NPROD];
    logic signed [DW-1:0] sel_xi [NPROD];
    logic signed [PW-1:0] p_re [NPROD];
    logic signed [PW-1:0] p_im [NPROD];

    logic                 s1_valid;
    logic [KW-1:0]        s1_bin;
    logic signed [DW-1:0] s1_are;
    logic signed [DW-1:0] s1_aim;

    // Twiddle angles: k, 2k, 3k for the lower bin; k+N/4 and 3k+3N/4 for the upper.
    always_comb begin
        k_ext  = BW'(in_bin);
        ang[0] = k_ext;
        ang[1] = BW'(k_ext * 2);
        ang[2] = BW'(k_ext * 3);
        ang[3] = BW'(k_ext + BW'(NSUB));
        ang[4] = BW'(k_ext * 3 + 3 * NSUB);
    end

    fftc_twiddle #(.NPT(NPT), .FRAC(FRAC), .TW(TW), .NANG(NANG)) u_tw (
        .ang (ang),
        .wr  (tw_r),
        .wi  (tw_i)
    );

    // Route twiddles and data to the six multipliers; upper C reuses negated 2k twiddle.
    always_comb begin
        sel_wr[0] = tw_r[0];  sel_wi[0] = tw_i[0];  sel_xr[0] = b_re; sel_xi[0] = b_im;
        sel_wr[1] = tw_r[1];  sel_wi[1] = tw_i[1];  sel_xr[1] = c_re; sel_xi[1] = c_im;
        sel_wr[2] = tw_r[2];  sel_wi[2] = tw_i[2];  sel_xr[2] = d_re; sel_xi[2] = d_im;
        sel_wr[3] = tw_r[3];  sel_wi[3] = tw_i[3];  sel_xr[3] = b_re; sel_xi[3] = b_im;
        sel_wr[4] = -tw_r[1]; sel_wi[4] = -tw_i[1]; sel_xr[4] = c_re; sel_xi[4] = c_im;
        sel_wr[5] = tw_r[4];  sel_wi[5] = tw_i[4];  sel_xr[5] = d_re; sel_xi[5] = d_im;
    end

    for (genvar g = 0; g < NPROD; g++) begin : g_mul
        fftc_cmul #(.DW(DW), .TW(TW), .FRAC(FRAC)) u_mul (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (sel_wr[g]),
            .wi    (sel_wi[g]),
            .xr    (sel_xr[g]),
            .xi    (sel_xi[g]),
            .pr    (p_re[g]),
            .pi    (p_im[g])
        );
    end

    // Stage 1 side path: carry valid, bin and the untwiddled A term alongside products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_bin   <= '0;
            s1_are   <= '0;
            s1_aim   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_bin   <= in_bin;
            s1_are   <= a_re;
            s1_aim   <= a_im;
        end
    end

    // Stage 2: four-term sums for both bins, plus the bin indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_lo_bin <= '0;
            out_hi_bin <= '0;
            lo_re      <= '0;
            lo_im      <= '0;
            hi_re      <= '0;
            hi_im      <= '0;
        end else begin
            out_valid  <= s1_valid;
            out_lo_bin <= {2'b00, s1_bin};
            out_hi_bin <= {2'b01, s1_bin};
            lo_re <= OW'(s1_are) + OW'(p_re[0]) + OW'(p_re[1]) + OW'(p_re[2]);
            lo_im <= OW'(s1_aim) + OW'(p_im[0]) + OW'(p_im[1]) + OW'(p_im[2]);
            hi_re <= OW'(s1_are) + OW'(p_re[3]) + OW'(p_re[4]) + OW'(p_re[5]);
            hi_im <= OW'(s1_aim) + OW'(p_im[3]) + OW'(p_im[4]) + OW'(p_im[5]);
        end
    end

    // R6: results appear exactly two clocks after an accepted set.
    a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 2) || !$past(rst_n) || !$past(rst_n, 2));

    // R7: reported bins are the accepted k and k + NSUB.
    a_r7_bin_pair: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_lo_bin == BW'($past(in_bin, 2))
                       && out_hi_bin == out_lo_bin + BW'(NSUB)));

    // R3: every looked-up twiddle at angle k has unit magnitude within rounding.
    a_r3_twiddle_unit: assert property (@(posedge clk) disable iff (!rst_n)
        ((longint'(tw_r[0]) * tw_r[0] + longint'(tw_i[0]) * tw_i[0]
          - (longint'(1) <<< (2 * FRAC))) < (longint'(1) <<< (FRAC + 2)))
        && ((longint'(tw_r[0]) * tw_r[0] + longint'(tw_i[0]) * tw_i[0]
          - (longint'(1) <<< (2 * FRAC))) > -(longint'(1) <<< (FRAC + 2))));

    // R10: sums stay inside seven times full scale, so nothing wraps.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (longint'(lo_re) <= LIMIT && longint'(lo_re) >= -LIMIT
                    && longint'(hi_re) <= LIMIT && longint'(hi_re) >= -LIMIT
                    && longint'(lo_im) <= LIMIT && longint'(lo_im) >= -LIMIT
                    && longint'(hi_im) <= LIMIT && longint'(hi_im) >= -LIMIT));
endmodule

// File: tb/sim_fft_half_combiner.sv
// Bench for fft_half_combiner: directed corners plus seeded random sets,
// compared against a floating-point twiddle model with the same fixed-point rules.
module sim_fft_half_combiner;
    localparam int  NPT  = 4096;
    localparam int  NSUB = 1024;
    localparam real TWO_PI = 6.283185307179586476925;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [9:0] in_bin = '0;
    logic signed [17:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic signed [17:0] c_re = '0, c_im = '0, d_re = '0, d_im = '0;
    logic out_valid;
    logic [11:0] out_lo_bin, out_hi_bin;
    logic signed [21:0] lo_re, lo_im, hi_re, hi_im;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit     v;
        int     k;
        longint lr, li, hr, hi;
        string  tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    fft_half_combiner u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bin(in_bin),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .c_re(c_re), .c_im(c_im), .d_re(d_re), .d_im(d_im),
        .out_valid(out_valid), .out_lo_bin(out_lo_bin), .out_hi_bin(out_hi_bin),
        .lo_re(lo_re), .lo_im(lo_im), .hi_re(hi_re), .hi_im(hi_im)
    );

    // R3: round to nearest, ties away from zero.
    function automatic longint rnd_real(input real v);
        if (v >= 0.0) return longint'($rtoi(v + 0.5));
        return -longint'($rtoi(-v + 0.5));
    endfunction
    function automatic longint twr(input int m);
        return rnd_real($cos(TWO_PI * real'(m % NPT) / real'(NPT)) * 1048576.0);
    endfunction
    function automatic longint twi(input int m);
        return rnd_real(-$sin(TWO_PI * real'(m % NPT) / real'(NPT)) * 1048576.0);
    endfunction
    // R4: add half, arithmetic shift by 20.
    function automatic longint rm(input longint t, input longint x);
        return (t * x + 524288) >>> 20;
    endfunction

    task automatic cmp(input string name, input longint got, input longint expv);
        checks++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", name, got, expv);
        end
    endtask

    task automatic compare_one(input exp_t e);
        cmp({e.tag, " R6 out_valid"}, longint'(out_valid), longint'(e.v));
        if (e.v) begin
            cmp({e.tag, " R1 lo_re"}, longint'(lo_re), e.lr);
            cmp({e.tag, " R1 lo_im"}, longint'(lo_im), e.li);
            cmp({e.tag, " R2 hi_re"}, longint'(hi_re), e.hr);
            cmp({e.tag, " R2 hi_im"}, longint'(hi_im), e.hi);
            cmp({e.tag, " R7 lo_bin"}, longint'(out_lo_bin), longint'(e.k));
            cmp({e.tag, " R7 hi_bin"}, longint'(out_hi_bin), longint'(e.k + NSUB));
        end
    endtask

    // One clock: check the result due now, then drive the next set and queue its model.
    task automatic step(input bit v, input int k, input string tag,
                        input longint ar, input longint ai, input longint br, input longint bi,
                        input longint cr, input longint ci, input longint dr, input longint di);
        exp_t e;
        longint w2r, w2i;
        @(negedge clk);
        if (q.size() >= 2) compare_one(q.pop_front());
        in_valid = v; in_bin = 10'(k);
        a_re = 18'(ar); a_im = 18'(ai); b_re = 18'(br); b_im = 18'(bi);
        c_re = 18'(cr); c_im = 18'(ci); d_re = 18'(dr); d_im = 18'(di);
        e.v = v; e.k = k; e.tag = tag;
        e.lr = ar + rm(twr(k), br) - rm(twi(k), bi)
                  + rm(twr(2*k), cr) - rm(twi(2*k), ci)
                  + rm(twr(3*k), dr) - rm(twi(3*k), di);
        e.li = ai + rm(twi(k), br) + rm(twr(k), bi)
                  + rm(twi(2*k), cr) + rm(twr(2*k), ci)
                  + rm(twi(3*k), dr) + rm(twr(3*k), di);
        // R5: upper second-power twiddle is the negated lower one.
        w2r = -twr(2*k);
        w2i = -twi(2*k);
        e.hr = ar + rm(twr(k+NSUB), br) - rm(twi(k+NSUB), bi)
                  + rm(w2r, cr) - rm(w2i, ci)
                  + rm(twr(3*(k+NSUB)), dr) - rm(twi(3*(k+NSUB)), di);
        e.hi = ai + rm(twi(k+NSUB), br) + rm(twr(k+NSUB), bi)
                  + rm(w2i, cr) + rm(w2r, ci)
                  + rm(twi(3*(k+NSUB)), dr) + rm(twr(3*(k+NSUB)), di);
        q.push_back(e);
    endtask

    function automatic longint r18();
        logic [17:0] t;
        t = 18'($urandom);
        return longint'($signed(t));
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240817));
        // R8: drive a busy input during reset; outputs must stay cleared.
        in_valid = 1'b1; in_bin = 10'd77; a_re = 18'sd500; b_re = 18'sd900;
        repeat (4) @(posedge clk);
        @(negedge clk);
        cmp("R8 out_valid", longint'(out_valid), 0);
        cmp("R8 lo_re", longint'(lo_re), 0);
        cmp("R8 hi_im", longint'(hi_im), 0);
        cmp("R8 out_hi_bin", longint'(out_hi_bin), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R9: unit twiddle at k=0.
        step(1, 0, "R9", 1000, -2000, 3000, 4000, -5000, 6000, 7000, -8000);
        step(1, 0, "R9", -131072, 131071, 12345, -54321, 1, -1, 77, 99);
        // R5: only C present so the reused negated twiddle drives the upper bin.
        step(1, 0, "R5", 0, 0, 0, 0, 70001, -30003, 0, 0);
        step(1, 1, "R5", 0, 0, 0, 0, -90001, 11111, 0, 0);
        step(1, 700, "R5", 0, 0, 0, 0, 123457, 98765, 0, 0);
        // R3: only B present at quadrant points and the last bin.
        step(1, 256, "R3", 0, 0, 100001, -50001, 0, 0, 0, 0);
        step(1, 1023, "R3", 0, 0, -77777, 33333, 0, 0, 0, 0);
        // R4: small odd values near rounding ties at the 45-degree twiddle.
        step(1, 512, "R4", 0, 0, 1, -1, 3, -3, -1, 1);
        step(1, 512, "R4", 0, 0, -5, 7, 1, 1, -9, 11);
        step(0, 5, "R6", 1, 2, 3, 4, 5, 6, 7, 8);
        // R10: full scale in both directions.
        step(1, 0, "R10", 131071, 131071, 131071, 131071, 131071, 131071, 131071, 131071);
        step(1, 0, "R10", -131072, -131072, -131072, -131072, -131072, -131072, -131072, -131072);
        step(1, 341, "R10", 131071, -131072, 131071, -131072, -131072, 131071, 131071, 131071);
        step(1, 1023, "R10", -131072, -131072, 131071, 131071, -131072, 131071, -131072, 131071);

        // Random sets with idle gaps; R1 and R2 across all bins.
        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 4) != 0, int'($urandom % NSUB), "RND",
                 r18(), r18(), r18(), r18(), r18(), r18(), r18(), r18());
        end
        for (int n = 0; n < 3; n++) step(0, 0, "R6", 0, 0, 0, 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule